// File: doc/BRIEF.md
# Configurable SPI Master/Slave Byte Engine

This block moves one byte at a time over a four-wire serial link. It can act as the clock-driving master or as a slave clocked by a remote master. A single 8-bit control word sets the following:

- whether the block is on;
- which role it plays;
- the active level of the slave select;
- the resting level of the master clock;
- the clock edge on which incoming bits are captured;
- a 3-bit rate code.

Software loads a byte and pulses `start`. In master mode this launches a transfer. In slave mode it arms the byte that is returned to the remote master. When the byte has been exchanged, the received value appears on `rx_data` and `done` rises.

Outgoing bits change only on the clock edge that is not the capture edge. Each bit is therefore held steady for a whole clock period centred on the capture edge, with half a period of setup and half a period of hold. A group-select input routes every link signal to one of two pin groups. The unselected group is left undriven.

Top module: `spi_xcvr`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x08, `done` is 0 and every output-enable on both pin groups is 0.
- R2: A write through `cfg_we`/`cfg_wdata` is read back on `cfg_rdata` from the next cycle. Control bit layout: bit 7 on, bit 6 master (1) or slave (0), bit 5 slave select active high (1) or low (0), bit 4 master clock rests high (1) or low (0), bit 3 capture on rising (1) or falling (0) edge, bits 2:0 rate code.
- R3: With bit 7 clear, no pin is driven, `start` is ignored and `done` stays 0.
- R4: An idle, enabled master drives its clock at the resting level of bit 4. It enables its clock and data-out pins and never drives the slave data-out pin.
- R5: In master mode each clock half-period lasts 2^code system clocks. A transfer makes 16 clock edges, and the k-th edge appears k*2^code cycles after the cycle in which `start` was sampled.
- R6: Data leaves MSB first. The first bit is on the data-out pin from the cycle after `start`, and each later bit replaces it on a non-capture edge.
- R7: Bit 3 alone picks the capture edge, rising or falling, for any resting level. Received bits are assembled MSB first.
- R8: A master sets `done` and updates `rx_data` on its sixteenth clock edge. `done` clears on an accepted `start` or on an `rx_rd` pulse.
- R9: A slave whose select input is at the inactive level (per bit 5) ignores clock edges and does not drive its data-out pin.
- R10: A selected slave captures data on the chosen edge and drives the armed byte MSB first. It sets `done` with the received byte after the eighth capture edge.
- R11: Deselecting a slave in mid-byte discards the partial byte without setting `done`. The next byte restarts from bit 7 of the armed value.
- R12: `map_sel` picks the pin group used for every link signal. The other group has all of its output-enables at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write value |
| cfg_rdata | output | 8 | Current control word |
| map_sel | input | GW | Pin group select |
| start | input | 1 | Start transfer (master) / arm byte (slave) |
| rx_rd | input | 1 | Receive data read strobe, clears `done` |
| tx_data | input | DW | Byte to send |
| rx_data | output | DW | Last received byte |
| done | output | 1 | Byte complete flag |
| sck_i | input | NGRP | Serial clock input per group |
| sck_o | output | NGRP | Serial clock output per group |
| sck_oe | output | NGRP | Serial clock output enable per group |
| mosi_i | input | NGRP | Master-to-slave data input per group |
| mosi_o | output | NGRP | Master-to-slave data output per group |
| mosi_oe | output | NGRP | Master-to-slave data output enable per group |
| miso_i | input | NGRP | Slave-to-master data input per group |
| miso_o | output | NGRP | Slave-to-master data output per group |
| miso_oe | output | NGRP | Slave-to-master data output enable per group |
| cs_i | input | NGRP | Slave select input per group |

## Verification
The bench models the master clock and data lines for every cycle of each transfer. It covers all four pairings of resting level and capture edge, because these decide whether data shifts on even or odd edges. A design that mixed them up would put the wrong bit on the pin or finish one half-period early.

The fastest rate code (one-cycle half-periods) and the slowest one are both run. These expose divider off-by-one errors and edges that fire one cycle late.

On the slave side, the bench drives the clock with select held inactive and aborts a byte after three bits. A design that ignored the select level or kept the partial count would flag `done` falsely or return a shifted byte. Transfers on the second pin group catch a mux that listens to, or drives, the wrong group.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;

  typedef struct packed {
    logic       en;
    logic       master;
    logic       cs_hi;
    logic       idle_hi;
    logic       rise;
    logic [2:0] rate;
  } spi_ctl_t;

  localparam logic [7:0] CTL_RESET = 8'h08;

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CW = (1 << RATE_W);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = (CW'(1) << rate) - CW'(1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_xcvr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  spi_ctl_t      ctl,
  input  logic          start,
  input  logic          rd,
  input  logic [DW-1:0] tx_data,
  input  logic          tick,
  input  logic          miso_in,
  input  logic          s_sck,
  input  logic          s_mosi,
  input  logic          s_cs,
  output logic          busy,
  output logic          sck_q,
  output logic          shout,
  output logic          sel,
  output logic [DW-1:0] rx_data,
  output logic          done
);
  localparam int            SW   = $clog2(DW) + 1;
  localparam logic [SW-1:0] LAST = SW'(DW);

  logic [DW-1:0] tx_sh, tx_hold, rx_sh, rx_nx;
  logic [SW-1:0] smp, smp_nx;
  logic s_sck_d, m_on, s_on, edge_v, new_lvl, din, is_smp, is_shf, fin;

  always_comb begin
    m_on    = ctl.en & ctl.master;
    s_on    = ctl.en & ~ctl.master;
    sel     = s_on & (s_cs == ctl.cs_hi);
    edge_v  = m_on ? (busy & tick) : (sel & (s_sck != s_sck_d));
    new_lvl = m_on ? ~sck_q : s_sck;
    din     = m_on ? miso_in : s_mosi;
    is_smp  = edge_v & (new_lvl == ctl.rise);
    is_shf  = edge_v & ~is_smp & (smp != '0) & (smp < LAST);
    rx_nx   = {rx_sh[DW-2:0], din};
    smp_nx  = is_smp ? smp + 1'b1 : smp;
    fin     = m_on ? (edge_v & (new_lvl == ctl.idle_hi) & (smp_nx == LAST))
                   : (is_smp & (smp_nx == LAST));
  end

  assign shout = tx_sh[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sck_q   <= 1'b0;
      s_sck_d <= 1'b0;
      tx_sh   <= '0;
      tx_hold <= '0;
      rx_sh   <= '0;
      rx_data <= '0;
      smp     <= '0;
      done    <= 1'b0;
    end else begin
      s_sck_d <= s_sck;
      if (!ctl.en) begin
        busy <= 1'b0;
        smp  <= '0;
      end else if (start && !busy) begin
        done    <= 1'b0;
        tx_sh   <= tx_data;
        tx_hold <= tx_data;
        smp     <= '0;
        busy    <= ctl.master;
      end else if (edge_v) begin
        if (is_smp) rx_sh <= rx_nx;
        if (is_shf) tx_sh <= {tx_sh[DW-2:0], 1'b0};
        smp <= smp_nx;
        if (fin) begin
          done    <= 1'b1;
          rx_data <= is_smp ? rx_nx : rx_sh;
          busy    <= 1'b0;
          smp     <= '0;
          tx_sh   <= tx_hold;
        end else if (rd) begin
          done <= 1'b0;
        end
      end else begin
        if (rd) done <= 1'b0;
        if (s_on && !sel && smp != '0) begin
          smp   <= '0;
          tx_sh <= tx_hold;
        end
      end
      if (m_on && !busy)      sck_q <= ctl.idle_hi;
      else if (m_on && edge_v) sck_q <= new_lvl;
    end
  end

  AST_SMP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    smp <= LAST); // R10
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    (start && ctl.en && !busy) |=> !done); // R8
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (m_on && !busy && $past(m_on && !busy) && $stable(ctl)) |-> (sck_q == ctl.idle_hi)); // R4
  AST_DONE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(edge_v)); // R8

endmodule

// File: rtl/spi_pin_route.sv
module spi_pin_route #(
  parameter int NGRP = 2,
  parameter int GW   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [GW-1:0]   map_sel,
  input  logic            m_on,
  input  logic            sel,
  input  logic            sck_q,
  input  logic            shout,
  input  logic [NGRP-1:0] sck_i,
  input  logic [NGRP-1:0] mosi_i,
  input  logic [NGRP-1:0] miso_i,
  input  logic [NGRP-1:0] cs_i,
  output logic [NGRP-1:0] sck_o,
  output logic [NGRP-1:0] sck_oe,
  output logic [NGRP-1:0] mosi_o,
  output logic [NGRP-1:0] mosi_oe,
  output logic [NGRP-1:0] miso_o,
  output logic [NGRP-1:0] miso_oe,
  output logic            sck_in,
  output logic            mosi_in,
  output logic            miso_in,
  output logic            cs_in
);
  logic [NGRP-1:0] grp_act;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      logic here;
      assign here       = (map_sel == GW'(g));
      assign sck_o[g]   = here & sck_q;
      assign sck_oe[g]  = here & m_on;
      assign mosi_o[g]  = here & shout;
      assign mosi_oe[g] = here & m_on;
      assign miso_o[g]  = here & shout;
      assign miso_oe[g] = here & sel;
      assign grp_act[g] = sck_oe[g] | mosi_oe[g] | miso_oe[g];
    end
  endgenerate

  assign sck_in  = sck_i[map_sel];
  assign mosi_in = mosi_i[map_sel];
  assign miso_in = miso_i[map_sel];
  assign cs_in   = cs_i[map_sel];

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |-> (grp_act == '0)); // R3
  AST_SINGLE_GROUP: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_act)); // R12

endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int  DW   = 8,
  parameter int  NGRP = 2,
  parameter int  SYNC = 2,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic [GW-1:0]   map_sel,
  input  logic            start,
  input  logic            rx_rd,
  input  logic [DW-1:0]   tx_data,
  output logic [DW-1:0]   rx_data,
  output logic            done,
  input  logic [NGRP-1:0] sck_i,
  output logic [NGRP-1:0] sck_o,
  output logic [NGRP-1:0] sck_oe,
  input  logic [NGRP-1:0] mosi_i,
  output logic [NGRP-1:0] mosi_o,
  output logic [NGRP-1:0] mosi_oe,
  input  logic [NGRP-1:0] miso_i,
  output logic [NGRP-1:0] miso_o,
  output logic [NGRP-1:0] miso_oe,
  input  logic [NGRP-1:0] cs_i
);
  logic [7:0] cfg_q;
  spi_ctl_t   ctl;
  logic       tick, busy, sck_q, shout, sel, m_on;
  logic       p_sck, p_mosi, p_miso, p_cs;
  logic [2:0] syncd;

  assign ctl       = spi_ctl_t'(cfg_q);
  assign cfg_rdata = cfg_q;
  assign m_on      = ctl.en & ctl.master;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CTL_RESET;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  spi_rate_gen #(.RATE_W(3)) u_rate (
    .clk(clk), .rst(rst), .run(busy), .rate(ctl.rate), .tick(tick)
  );

  spi_sync #(.W(3), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .d({p_sck, p_mosi, p_cs}), .q(syncd)
  );

  spi_shift_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .ctl(ctl), .start(start), .rd(rx_rd),
    .tx_data(tx_data), .tick(tick), .miso_in(p_miso),
    .s_sck(syncd[2]), .s_mosi(syncd[1]), .s_cs(syncd[0]),
    .busy(busy), .sck_q(sck_q), .shout(shout), .sel(sel),
    .rx_data(rx_data), .done(done)
  );

  spi_pin_route #(.NGRP(NGRP), .GW(GW)) u_route (
    .clk(clk), .rst(rst), .en(ctl.en), .map_sel(map_sel), .m_on(m_on),
    .sel(sel), .sck_q(sck_q), .shout(shout),
    .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i), .cs_i(cs_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_o(miso_o), .miso_oe(miso_oe),
    .sck_in(p_sck), .mosi_in(p_mosi), .miso_in(p_miso), .cs_in(p_cs)
  );

endmodule

// File: tb/spi_xcvr_tb.sv
module spi_xcvr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [0:0] map_sel = 1'b0;
  logic       start = 1'b0;
  logic       rx_rd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic       done;
  logic [1:0] sck_i = 2'b00, mosi_i = 2'b00, miso_i = 2'b00, cs_i = 2'b11;
  logic [1:0] sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xcvr u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .map_sel(map_sel), .start(start), .rx_rd(rx_rd),
    .tx_data(tx_data), .rx_data(rx_data), .done(done),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .cs_i(cs_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_start(input logic [7:0] v);
    @(negedge clk);
    tx_data = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic int shifts(input int e, input bit lead);
    int s;
    if (lead) s = e / 2;
    else      s = (e < 3) ? 0 : (e - 1) / 2;
    return (s > 7) ? 7 : s;
  endfunction

  // Reference model of a master transfer, compared every cycle.
  task automatic master_xfer(input int code, input bit idle, input bit rise,
                             input logic [7:0] tx, input logic [7:0] peer, input int grp);
    int  h;
    bit  lead;
    map_sel = grp[0];
    cfg_write({1'b1, 1'b1, 1'b0, idle, rise, code[2:0]});
    wait_n(2);
    chk("R4 idle sck level", sck_o[grp], idle);
    chk("R4 sck enable", sck_oe[grp], 1);
    chk("R4 mosi enable", mosi_oe[grp], 1);
    chk("R4 miso not driven", miso_oe, 0);
    h = 1 << code;
    lead = (rise != idle);
    @(negedge clk);
    tx_data = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= 16 * h; j++) begin
      int e;
      logic b;
      e = j / h;
      if (j == 0) chk("R8 start clears done", done, 0);
      if (j < 16 * h) begin
        chk("R5 sck waveform", sck_o[grp], idle ^ e[0]);
        chk("R6 mosi bit", mosi_o[grp], tx[7 - shifts(e, lead)]);
        chk("R12 other group quiet", sck_oe[1 - grp] | mosi_oe[1 - grp], 0);
      end else begin
        chk("R8 done after 16 edges", done, 1);
        chk("R7 received byte", rx_data, peer);
        chk("R5 sck back to idle", sck_o[grp], idle);
      end
      b = peer[7 - shifts(e, lead)];
      miso_i[grp] = b;
      miso_i[1 - grp] = ~b;
      if (j < 16 * h) @(negedge clk);
    end
  endtask

  task automatic slave_setup(input bit cs_hi, input bit rise, input bit idle,
                             input logic [7:0] tx, input int grp);
    map_sel = grp[0];
    cs_i = {~cs_hi, ~cs_hi};
    sck_i[grp] = idle;
    cfg_write({1'b1, 1'b0, cs_hi, 1'b0, rise, 3'd0});
    wait_n(5);
    pulse_start(tx);
    wait_n(2);
    chk("R9 miso off while deselected", miso_oe[grp], 0);
  endtask

  task automatic slave_bits(input bit rise, input bit idle, input logic [7:0] md,
                            input logic [7:0] tx, input int nbits, input bit chk_miso,
                            input int grp);
    int s;
    bit lvl;
    s = 0;
    lvl = idle;
    mosi_i[grp] = md[7];
    for (int k = 0; k < 2 * nbits; k++) begin
      bit nl;
      wait_n(HALF);
      nl = ~lvl;
      if (nl == rise) begin
        if (chk_miso) begin
          chk("R10 miso bit", miso_o[grp], tx[7 - s]);
          chk("R10 miso enabled", miso_oe[grp], 1);
        end
        sck_i[grp] = nl;
        s++;
      end else begin
        sck_i[grp] = nl;
        if (s < 8) mosi_i[grp] = md[7 - s];
      end
      lvl = nl;
    end
    wait_n(HALF);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    chk("R1 reset control", cfg_rdata, 8'h08);
    chk("R1 reset done", done, 0);
    chk("R1 reset enables", {sck_oe, mosi_oe, miso_oe}, 0);

    cfg_write(8'hA5);
    chk("R2 readback", cfg_rdata, 8'hA5);
    cfg_write(8'h5C);
    chk("R2 readback", cfg_rdata, 8'h5C);

    // R3: disabled master ignores start
    cfg_write(8'h48);
    pulse_start(8'hFF);
    wait_n(20);
    chk("R3 no drive when off", {sck_oe, mosi_oe, miso_oe}, 0);
    chk("R3 done stays low", done, 0);

    master_xfer(0, 1'b0, 1'b1, 8'hA5, 8'h3C, 0);
    master_xfer(2, 1'b1, 1'b1, 8'h96, 8'hC3, 1);
    master_xfer(1, 1'b0, 1'b0, 8'h0F, 8'hF0, 0);
    master_xfer(7, 1'b1, 1'b0, 8'h81, 8'h7E, 0);

    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    chk("R8 read clears done", done, 0);

    // R10: slave, select active low, capture rising, clock rests low
    slave_setup(1'b0, 1'b1, 1'b0, 8'h5A, 0);
    cs_i[0] = 1'b0;
    wait_n(5);
    slave_bits(1'b1, 1'b0, 8'h99, 8'h5A, 8, 1'b1, 0);
    chk("R10 slave done", done, 1);
    chk("R10 slave rx", rx_data, 8'h99);
    cs_i[0] = 1'b1;

    // R10/R9: select active high, capture falling, group 1
    slave_setup(1'b1, 1'b0, 1'b0, 8'hE1, 1);
    cs_i[1] = 1'b1;
    wait_n(5);
    slave_bits(1'b0, 1'b0, 8'h18, 8'hE1, 8, 1'b1, 1);
    chk("R10 slave done active-high select", done, 1);
    chk("R7 slave rx falling capture", rx_data, 8'h18);
    chk("R12 group 0 quiet", {sck_oe[0], mosi_oe[0], miso_oe[0]}, 0);
    cs_i[1] = 1'b0;

    // R9: deselected slave ignores a whole byte of clocks
    slave_setup(1'b1, 1'b1, 1'b0, 8'h33, 0);
    slave_bits(1'b1, 1'b0, 8'hC7, 8'h33, 8, 1'b0, 0);
    chk("R9 no done when deselected", done, 0);
    chk("R9 miso stays off", miso_oe[0], 0);

    // R11: abort after three bits, then a full byte
    slave_setup(1'b0, 1'b1, 1'b0, 8'hB4, 0);
    cs_i[0] = 1'b0;
    wait_n(5);
    slave_bits(1'b1, 1'b0, 8'hE0, 8'hB4, 3, 1'b1, 0);
    cs_i[0] = 1'b1;
    wait_n(8);
    chk("R11 abort leaves done low", done, 0);
    cs_i[0] = 1'b0;
    wait_n(5);
    slave_bits(1'b1, 1'b0, 8'h6D, 8'hB4, 8, 1'b1, 0);
    chk("R11 byte after abort done", done, 1);
    chk("R11 byte after abort rx", rx_data, 8'h6D);
    cs_i[0] = 1'b1;

    wait_n(4);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule